// File: doc/BRIEF.md
# Pipeline Interlock and Squash Controller

This unit is the control half of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It tracks the control view of each instruction as it moves down the pipe: a tag, a destination register index, two source indices, and whether it is a load, a store or a branch. Each cycle it compares the decode-stage sources against the destinations held in execute, memory and writeback. From that comparison it freezes fetch and decode and puts a bubble into execute. The datapath, register file and memory live elsewhere and follow the strobes this unit drives.

Two static inputs pick the operating variant. `fwd_ld_st` enables a short path from the data-memory read port to the data-memory write port, so a store may take its data from the load just ahead of it without waiting. `pred_bt` selects the branch policy. With it low, every branch is guessed not taken. With it high, backward branches are guessed taken and forward branches not taken. Each branch carries its real outcome down to execute. If that outcome differs from the guess, the unit cancels the two younger instructions (the one in decode and the one being offered by fetch) and signals the redirect.

Top module: `interlock_unit`

## Requirements
- R1: After reset, fetch is accepted (`in_ready`=1) and `fd_hold`, `squash`, `retire_valid`, `wb_en`, `mem_wr` and `mem_fwd` are all 0.
- R2: With `fwd_ld_st`=0, a decode instruction whose source index matches the destination of a valid instruction in execute, memory or writeback is held. While it is held, `fd_hold`=1, `in_ready`=0, `ex_bubble`=1, and the decode tag does not change.
- R3: A held instruction waits 3 cycles when its producer is one instruction ahead, 2 cycles when the producer is two ahead, 1 cycle when it is three ahead, and 0 cycles when it is four or more ahead. No instruction is held more than 3 consecutive cycles.
- R4: Register index 15 means "no register". As a source it never causes a hold. As a destination it never produces `wb_en`.
- R5: With `fwd_ld_st`=1, a store placed directly after a load whose destination equals the store's data source (src2) issues without a hold. While that store is in the memory stage, `mem_fwd`=1. A dependency through the store's address source (src1), or a non-store consumer of the load, is still held 3 cycles. `mem_fwd` is never 1 when `fwd_ld_st`=0.
- R6: `pred_taken` = `in_branch` AND `pred_bt` AND `in_back`, so it is always 0 when `pred_bt`=0.
- R7: When a branch in execute has an outcome different from its prediction, `squash` is 1 for that cycle. The instruction in decode and the one offered by fetch that cycle never retire and never write.
- R8: When a misprediction and a decode hold occur in the same cycle, the cancel wins: `fd_hold`=0, fetch is accepted, and the held instruction is discarded.
- R9: Every instruction that is not cancelled retires exactly once, in program order, on `retire_tag`/`retire_valid`. `wb_en` is 1 only for retiring instructions with a destination other than 15, and `wb_dst` carries that destination.
- R10: `mem_wr` is 1 once per retiring store in its memory-stage cycle. Bubbles never assert `mem_wr`, `mem_rd`, `mem_fwd` or `wb_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_ld_st | input | 1 | Enables the memory-output to memory-input forward path |
| pred_bt | input | 1 | 0: all branches guessed not taken; 1: backward taken, forward not taken |
| in_valid | input | 1 | Fetch offers an instruction |
| in_ready | output | 1 | Offered instruction is accepted this cycle |
| in_tag | input | TAG_W | Instruction tag |
| in_dst | input | RIDX_W | Destination index, 15 = none |
| in_src1 | input | RIDX_W | First source (store address), 15 = none |
| in_src2 | input | RIDX_W | Second source (store data), 15 = none |
| in_load | input | 1 | Instruction is a load |
| in_store | input | 1 | Instruction is a store |
| in_branch | input | 1 | Instruction is a conditional branch |
| in_back | input | 1 | Branch target lies behind the branch |
| in_taken | input | 1 | Real branch outcome, resolved in execute |
| pred_taken | output | 1 | Guess for the offered branch |
| fd_hold | output | 1 | Fetch and decode registers hold |
| ex_bubble | output | 1 | Execute register receives a bubble |
| squash | output | 1 | Misprediction: cancel younger work, redirect fetch |
| mem_rd | output | 1 | Load in memory stage |
| mem_wr | output | 1 | Store in memory stage |
| mem_fwd | output | 1 | Store data taken from memory read output |
| wb_en | output | 1 | Register write in writeback |
| wb_dst | output | RIDX_W | Register written |
| retire_valid | output | 1 | Instruction retires this cycle |
| retire_tag | output | TAG_W | Tag of retiring instruction |

## Verification
On every cycle the assertions check four things: the hold bound of three cycles, that the decode tag stays stable during a hold, that a cancel empties decode and execute, and that an instruction never leaves decode while its source is still pending in execute without forwarding. They also check that index 15 never holds decode and that the forward strobe and the prediction follow their mode inputs. The bench's scenarios show what a single cycle cannot: the exact hold length for each producer distance, the lost stall under the load-to-store path, which two instructions disappear after each misprediction under both policies, and the retirement order compared against the correct-path program.

// File: rtl/interlock_unit.sv
module interlock_unit #(
  parameter int TAG_W  = 8,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_ld_st,
  input  logic              pred_bt,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [RIDX_W-1:0] in_dst,
  input  logic [RIDX_W-1:0] in_src1,
  input  logic [RIDX_W-1:0] in_src2,
  input  logic              in_load,
  input  logic              in_store,
  input  logic              in_branch,
  input  logic              in_back,
  input  logic              in_taken,
  output logic              pred_taken,
  output logic              fd_hold,
  output logic              ex_bubble,
  output logic              squash,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_fwd,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_dst,
  output logic              retire_valid,
  output logic [TAG_W-1:0]  retire_tag
);
  localparam logic [RIDX_W-1:0] NOREG = '1;

  logic              d_v, d_ld, d_st, d_br, d_pred, d_tk;
  logic [TAG_W-1:0]  d_tag;
  logic [RIDX_W-1:0] d_dst, d_src1, d_src2;

  logic              e_v, e_ld, e_st, e_br, e_pred, e_tk, e_byp;
  logic [TAG_W-1:0]  e_tag;
  logic [RIDX_W-1:0] e_dst;

  logic              m_v, m_ld, m_st, m_byp;
  logic [TAG_W-1:0]  m_tag;
  logic [RIDX_W-1:0] m_dst;

  logic              w_v;
  logic [TAG_W-1:0]  w_tag;
  logic [RIDX_W-1:0] w_dst;

  function automatic logic hit(input logic v, input logic [RIDX_W-1:0] dst,
                               input logic [RIDX_W-1:0] src);
    return v && (src != NOREG) && (dst == src);
  endfunction

  logic hz1, hz2_e, hz2_mw, byp_ok, hz2, mispred;

  assign hz1    = hit(e_v, e_dst, d_src1) | hit(m_v, m_dst, d_src1) | hit(w_v, w_dst, d_src1);
  assign hz2_e  = hit(e_v, e_dst, d_src2);
  assign hz2_mw = hit(m_v, m_dst, d_src2) | hit(w_v, w_dst, d_src2);
  assign byp_ok = fwd_ld_st & d_st & e_ld & hz2_e;
  assign hz2    = byp_ok ? 1'b0 : (hz2_e | hz2_mw);

  assign mispred    = e_v & e_br & (e_tk != e_pred);
  assign squash     = mispred;
  assign fd_hold    = d_v & (hz1 | hz2) & ~mispred;
  assign ex_bubble  = fd_hold | mispred;
  assign in_ready   = ~fd_hold;
  assign pred_taken = in_branch & pred_bt & in_back;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_v <= 1'b0;
      e_v <= 1'b0;
      m_v <= 1'b0;
      w_v <= 1'b0;
    end else begin
      if (mispred)       d_v <= 1'b0;
      else if (!fd_hold) d_v <= in_valid;
      e_v <= d_v & ~fd_hold & ~mispred;
      m_v <= e_v;
      w_v <= m_v;
    end
  end

  always_ff @(posedge clk) begin
    if (!fd_hold) begin
      d_tag  <= in_tag;
      d_dst  <= in_dst;
      d_src1 <= in_src1;
      d_src2 <= in_src2;
      d_ld   <= in_load;
      d_st   <= in_store;
      d_br   <= in_branch;
      d_pred <= pred_taken;
      d_tk   <= in_taken;
    end
    e_tag  <= d_tag;
    e_dst  <= d_dst;
    e_ld   <= d_ld;
    e_st   <= d_st;
    e_br   <= d_br;
    e_pred <= d_pred;
    e_tk   <= d_tk;
    e_byp  <= byp_ok;
    m_tag  <= e_tag;
    m_dst  <= e_dst;
    m_ld   <= e_ld;
    m_st   <= e_st;
    m_byp  <= e_byp;
    w_tag  <= m_tag;
    w_dst  <= m_dst;
  end

  assign mem_rd       = m_v & m_ld;
  assign mem_wr       = m_v & m_st;
  assign mem_fwd      = m_v & m_byp;
  assign wb_en        = w_v & (w_dst != NOREG);
  assign wb_dst       = w_dst;
  assign retire_valid = w_v;
  assign retire_tag   = w_tag;
endmodule

// File: rtl/interlock_unit_chk.sv
module interlock_unit_chk #(
  parameter int TAG_W  = 8,
  parameter int RIDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fwd_ld_st,
  input logic              pred_bt,
  input logic              pred_taken,
  input logic              fd_hold,
  input logic              squash,
  input logic              mem_fwd,
  input logic              d_v,
  input logic              e_v,
  input logic [TAG_W-1:0]  d_tag,
  input logic [RIDX_W-1:0] d_src1,
  input logic [RIDX_W-1:0] d_src2,
  input logic [RIDX_W-1:0] e_dst
);
  localparam logic [RIDX_W-1:0] NOREG = '1;
  logic [2:0] hold_run;

  always_ff @(posedge clk) begin
    if (!rst_n)       hold_run <= '0;
    else if (fd_hold) hold_run <= hold_run + 3'd1;
    else              hold_run <= '0;
  end

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fd_hold |-> (hold_run < 3'd3)); // R3
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    fd_hold |=> (d_v && d_tag == $past(d_tag))); // R2
  AST_NOFWD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_ld_st && d_v && !fd_hold && !squash && d_src1 != NOREG) |-> !(e_v && e_dst == d_src1)); // R2
  AST_NOREG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (d_v && d_src1 == NOREG && d_src2 == NOREG) |-> !fd_hold); // R4
  AST_FWD_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fwd |-> fwd_ld_st); // R5
  AST_PRED_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_bt |-> !pred_taken); // R6
  AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (!d_v && !e_v)); // R7
endmodule

bind interlock_unit interlock_unit_chk #(.TAG_W(TAG_W), .RIDX_W(RIDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fwd_ld_st(fwd_ld_st), .pred_bt(pred_bt),
  .pred_taken(pred_taken), .fd_hold(fd_hold), .squash(squash), .mem_fwd(mem_fwd),
  .d_v(d_v), .e_v(e_v), .d_tag(d_tag), .d_src1(d_src1), .d_src2(d_src2), .e_dst(e_dst)
);

// File: tb/interlock_unit_tb_top.sv
`timescale 1ns/1ps
module interlock_unit_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, fwd_ld_st, pred_bt, in_valid, in_ready;
  logic [7:0] in_tag, retire_tag;
  logic [3:0] in_dst, in_src1, in_src2, wb_dst;
  logic in_load, in_store, in_branch, in_back, in_taken;
  logic pred_taken, fd_hold, ex_bubble, squash, mem_rd, mem_wr, mem_fwd, wb_en, retire_valid;

  interlock_unit dut_i (.*);

  typedef struct packed {
    logic [7:0] tag;
    logic [3:0] dst, s1, s2;
    logic ld, st, br, bk, tk, wrong;
  } ins_t;

  typedef struct packed { logic [7:0] tag; logic [3:0] dst; } exp_t;

  ins_t prog [64];
  int   prog_n;
  int   hold_seen [64];
  exp_t sb_q [$];
  int   checks = 0, failures = 0;
  int   fwd_cnt = 0, wr_cnt = 0, sq_cnt = 0;
  logic [7:0] next_tag = 8'd1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] dst, s1, s2, input logic ld, st, br, bk, tk, wr);
    ins_t x;
    x = '{tag: next_tag, dst: dst, s1: s1, s2: s2, ld: ld, st: st, br: br, bk: bk, tk: tk, wrong: wr};
    next_tag++;
    prog[prog_n] = x;
    prog_n++;
  endtask

  task automatic add(input logic [3:0] dst, s1, s2, input logic ld, st, br, bk, tk);
    put(dst, s1, s2, ld, st, br, bk, tk, 1'b0);
    if (br && (tk != (pred_bt & bk))) begin
      put(4'd9, 4'hF, 4'hF, 0, 0, 0, 0, 0, 1'b1);
      put(4'd9, 4'hF, 4'hF, 0, 0, 0, 0, 0, 1'b1);
    end
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) add(4'hF, 4'hF, 4'hF, 0, 0, 0, 0, 0);
  endtask

  task automatic start(input logic lf, input logic bt);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; fwd_ld_st = lf; pred_bt = bt;
    prog_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fwd_cnt = 0; wr_cnt = 0; sq_cnt = 0;
  endtask

  task automatic run();
    for (int i = 0; i < prog_n; i++) begin
      hold_seen[i] = 0;
      @(negedge clk);
      in_valid = 1'b1; in_tag = prog[i].tag; in_dst = prog[i].dst;
      in_src1 = prog[i].s1; in_src2 = prog[i].s2; in_load = prog[i].ld;
      in_store = prog[i].st; in_branch = prog[i].br; in_back = prog[i].bk;
      in_taken = prog[i].tk;
      #1;
      chk(pred_taken == (prog[i].br & pred_bt & prog[i].bk), "R6 pred_taken",
          int'(pred_taken), int'(prog[i].br & pred_bt & prog[i].bk));
      while (!in_ready) begin
        hold_seen[i]++;
        chk(fd_hold && ex_bubble, "R2 hold/bubble during stall", int'(fd_hold), 1);
        @(negedge clk); #1;
      end
      if (!prog[i].wrong) sb_q.push_back('{tag: prog[i].tag, dst: prog[i].dst});
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(sb_q.size() == 0, "R9 all correct-path retired", sb_q.size(), 0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk); #5;
      if (rst_n) begin
        if (mem_fwd) fwd_cnt++;
        if (mem_wr)  wr_cnt++;
        if (squash)  sq_cnt++;
        if (!retire_valid) begin
          chk(!wb_en, "R10 bubble wb_en", int'(wb_en), 0);
        end else if (sb_q.size() == 0) begin
          chk(1'b0, "R7 unexpected retire", int'(retire_tag), -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(retire_tag == e.tag, "R9 retire order", int'(retire_tag), int'(e.tag));
          chk(wb_en == (e.dst != 4'hF), "R4 wb_en vs dst", int'(wb_en), int'(e.dst != 4'hF));
          if (e.dst != 4'hF) chk(wb_dst == e.dst, "R9 wb_dst", int'(wb_dst), int'(e.dst));
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; fwd_ld_st = 1'b0; pred_bt = 1'b0;
    in_tag = '0; in_dst = '1; in_src1 = '1; in_src2 = '1;
    in_load = 0; in_store = 0; in_branch = 0; in_back = 0; in_taken = 0;

    // R1 reset state
    start(1'b0, 1'b0);
    #1;
    chk(in_ready, "R1 in_ready", int'(in_ready), 1);
    chk(!fd_hold && !squash, "R1 hold/squash", int'(fd_hold | squash), 0);
    chk(!retire_valid && !wb_en, "R1 retire/wb", int'(retire_valid | wb_en), 0);
    chk(!mem_wr && !mem_fwd && !mem_rd, "R1 mem strobes", int'(mem_wr | mem_fwd | mem_rd), 0);

    // R2/R3/R4: producer distance 1,3,2,4 and index 15
    start(1'b0, 1'b0);
    add(4'd1, 4'hF, 4'hF, 0, 0, 0, 0, 0);   // 0
    add(4'd2, 4'd1, 4'hF, 0, 0, 0, 0, 0);   // 1 reads r1 (dist 1)
    add(4'd3, 4'hF, 4'hF, 0, 0, 0, 0, 0);   // 2
    add(4'd4, 4'hF, 4'hF, 0, 0, 0, 0, 0);   // 3
    add(4'hF, 4'hF, 4'd2, 0, 0, 0, 0, 0);   // 4 reads r2 (dist 3)
    add(4'd5, 4'hF, 4'hF, 0, 0, 0, 0, 0);   // 5
    add(4'hF, 4'hF, 4'hF, 0, 0, 0, 0, 0);   // 6
    add(4'hF, 4'd5, 4'hF, 0, 0, 0, 0, 0);   // 7 reads r5 (dist 2)
    add(4'hF, 4'hF, 4'hF, 0, 0, 0, 0, 0);   // 8 dst 15
    add(4'd6, 4'hF, 4'hF, 0, 0, 0, 0, 0);   // 9 reads 15 only
    fill(3);                                // 10..12
    add(4'hF, 4'd6, 4'd6, 0, 0, 0, 0, 0);   // 13 reads r6 (dist 4)
    fill(2);
    run();
    chk(hold_seen[2] == 3, "R3 distance 1 hold", hold_seen[2], 3);
    chk(hold_seen[5] == 1, "R3 distance 3 hold", hold_seen[5], 1);
    chk(hold_seen[8] == 2, "R3 distance 2 hold", hold_seen[8], 2);
    chk(hold_seen[10] == 0, "R4 index 15 no hold", hold_seen[10], 0);
    chk(hold_seen[14] == 0, "R3 distance 4 no hold", hold_seen[14], 0);

    // R5: load-to-store path, both modes
    for (int m = 1; m >= 0; m--) begin
      start(logic'(m), 1'b0);
      add(4'd3, 4'hF, 4'hF, 1, 0, 0, 0, 0);   // 0 load r3
      add(4'hF, 4'd1, 4'd3, 0, 1, 0, 0, 0);   // 1 store data r3
      add(4'hF, 4'hF, 4'hF, 0, 0, 0, 0, 0);   // 2
      add(4'd4, 4'hF, 4'hF, 1, 0, 0, 0, 0);   // 3 load r4
      add(4'hF, 4'd4, 4'hF, 0, 1, 0, 0, 0);   // 4 store addr r4
      add(4'd7, 4'hF, 4'hF, 1, 0, 0, 0, 0);   // 5 load r7
      add(4'd8, 4'hF, 4'd7, 0, 0, 0, 0, 0);   // 6 non-store reads r7
      fill(2);
      run();
      chk(hold_seen[2] == (m ? 0 : 3), "R5 store data hold", hold_seen[2], m ? 0 : 3);
      chk(fwd_cnt == m, "R5 mem_fwd count", fwd_cnt, m);
      chk(hold_seen[5] == 3, "R5 store address still holds", hold_seen[5], 3);
      chk(hold_seen[7] == 3, "R5 non-store consumer holds", hold_seen[7], 3);
      chk(wr_cnt == 2, "R10 mem_wr per store", wr_cnt, 2);
    end

    // R6/R7: branch policies
    for (int p = 0; p < 2; p++) begin
      start(1'b0, logic'(p));
      add(4'hF, 4'hF, 4'hF, 0, 0, 1, 1, 1);   // backward taken
      add(4'd2, 4'hF, 4'hF, 0, 0, 0, 0, 0);
      add(4'hF, 4'hF, 4'hF, 0, 0, 1, 0, 0);   // forward not taken
      add(4'hF, 4'hF, 4'hF, 0, 0, 1, 1, 0);   // backward not taken
      add(4'd3, 4'hF, 4'hF, 0, 0, 0, 0, 0);
      add(4'hF, 4'hF, 4'hF, 0, 0, 1, 0, 1);   // forward taken
      fill(3);
      run();
      chk(sq_cnt == 2, "R7 squash count", sq_cnt, 2);
    end

    // R8: cancel beats a hold in the same cycle
    start(1'b0, 1'b0);
    add(4'd5, 4'hF, 4'hF, 0, 0, 0, 0, 0);     // 0 writes r5
    put(4'hF, 4'hF, 4'hF, 0, 0, 1, 1, 1, 0);  // 1 mispredicted branch
    put(4'd9, 4'd5, 4'hF, 0, 0, 0, 0, 0, 1);  // 2 wrong path, reads r5
    put(4'd9, 4'hF, 4'hF, 0, 0, 0, 0, 0, 1);  // 3 wrong path
    fill(3);
    run();
    chk(hold_seen[3] == 0, "R8 cancel overrides hold", hold_seen[3], 0);
    chk(sq_cnt == 1, "R8 single squash", sq_cnt, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule